// File: doc/BRIEF.md
# Windowed Load/Store Address Aligner

This block sits between the load/store stage of a small RISC coprocessor and its two memory paths: a local scratch RAM and the shared external bus. For each request it forms the effective address in one of three ways. The first is a plain base register. The second is register 14 or 15 plus a scaled 5-bit immediate. The third is register 14 or 15 plus an index register. The block then decides whether that address lies inside the local RAM window and shapes the transfer for the access size: byte, word, long or 64-bit phrase.

Inside the window, word, long and phrase accesses are forced to their natural alignment. Outside it, addresses pass through unchanged. The one exception is a plain base-register long load, which always drops its two low address bits. A phrase becomes an ordered pair of long transfers on consecutive cycles. The first transfer carries the high-data holding register and the second carries the target register. A `busy` output stalls the issuing stage while the second transfer is still owed.

Every transfer is registered and appears on the memory side one cycle after its request is accepted. At most one transfer is issued per cycle.

Top module: `mau_top`

## Requirements
- R1: The effective address is selected by `req_mode`. Mode 0 uses `rm_val`. Mode 1 uses the selected base plus the immediate times 4, where an immediate of 0 means 32, giving an offset of 128. Mode 2 uses the selected base plus `rm_val`. The selected base is `r15_val` when `base_r15` is 1 and `r14_val` otherwise.
- R2: `mem_local` is 1 exactly when the effective address lies in 0x00F03000..0x00F03FFF, both ends included.
- R3: A long store (`req_size`=2) inside the window has address bits 1:0 cleared. Outside the window its address is left unchanged. Lanes are 4'b1111 and the data is `wr_data`.
- R4: A mode-0 long load has address bits 1:0 cleared wherever it points. A long load in mode 1 or mode 2 outside the window keeps its address unchanged.
- R5: A word access (`req_size`=1) inside the window has address bit 0 cleared. Outside the window the address is unchanged. The data is the low 16 bits of `wr_data`, zero-extended. Lanes are 4'b0011.
- R6: A byte access (`req_size`=0) is never realigned. Lane bit k (`mem_lanes[k]`) is the only one set, with k = address bits 1:0. The data byte sits at bits 8k+7:8k.
- R7: A phrase access (`req_size`=3) yields two long-sized transfers (`mem_size`=2) on consecutive cycles. The first goes to the base address, carries `hi_data` and has `mem_hi`=1. The second goes to base+4, carries `wr_data` and has `mem_hi`=0. Inside the window the base has bits 2:0 cleared; outside it is the effective address.
- R8: `busy` is 1 only in the cycle that presents the first half of a phrase. A request offered in that cycle is ignored and produces no transfer.
- R9: After reset, `mem_valid` and `busy` are 0. An accepted request appears on the memory side in the next cycle. Non-phrase requests on consecutive cycles produce transfers on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | 0 base, 1 base+imm*4, 2 base+index |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 phrase |
| base_r15 | input | 1 | Indexed modes: 1 selects r15, 0 selects r14 |
| rm_val | input | 32 | Base register (mode 0) or index register (mode 2) |
| r14_val | input | 32 | Contents of register 14 |
| r15_val | input | 32 | Contents of register 15 |
| imm5 | input | 5 | Immediate for mode 1 (0 means 32) |
| wr_data | input | 32 | Target register value (store data) |
| hi_data | input | 32 | High-data holding register value |
| busy | output | 1 | Second phrase half pending; requests ignored |
| mem_valid | output | 1 | A transfer is presented this cycle |
| mem_we | output | 1 | Transfer is a write |
| mem_local | output | 1 | 1 = local RAM port, 0 = external bus |
| mem_hi | output | 1 | Transfer belongs to the high-data register |
| mem_size | output | 2 | Transfer size code |
| mem_lanes | output | 4 | Byte-lane enables |
| mem_addr | output | 32 | Transfer address |
| mem_wdata | output | 32 | Write data |

## Verification
The bench probes both ends of the window, one address below it and one above it. A decoder that uses strict bounds or is off by one would send the edge accesses to the wrong port, or fail to align them. It compares a base-register long load with indexed long loads outside the window. A design that applied the unconditional clearing to every mode, or to none, would present the wrong address on one of them. It uses the zero immediate, which must add 128; a literal decode would add nothing. It checks phrase ordering and the data carried by each half, where a swapped pair would write the wrong register to the wrong address. Finally, it offers a request exactly in the busy cycle; a sequencer that accepted it would emit an extra transfer, and the scoreboard would flag it as unexpected.

// File: rtl/mau_pkg.sv
package mau_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    localparam int LANES = DATA_W / 8;

    localparam logic [1:0] SZ_BYTE   = 2'd0;
    localparam logic [1:0] SZ_WORD   = 2'd1;
    localparam logic [1:0] SZ_LONG   = 2'd2;
    localparam logic [1:0] SZ_PHRASE = 2'd3;

    localparam logic [1:0] EA_BASE = 2'd0;
    localparam logic [1:0] EA_IMM  = 2'd1;
    localparam logic [1:0] EA_IDX  = 2'd2;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic              loc_hit;
        logic              hi_half;
        logic [1:0]        size;
        logic [LANES-1:0]  lanes;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;
endpackage

// File: rtl/mau_ea_gen.sv
module mau_ea_gen
    import mau_pkg::*;
#(
    parameter int IMM_W = 5
) (
    input  logic [1:0]        mode,
    input  logic              sel_r15,
    input  logic [ADDR_W-1:0] rm_val,
    input  logic [ADDR_W-1:0] r14_val,
    input  logic [ADDR_W-1:0] r15_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] ea
);
    localparam int OFF_W = IMM_W + 3;

    logic [ADDR_W-1:0] base_sel;
    logic [OFF_W-1:0]  imm_off;

    always_comb begin
        base_sel = sel_r15 ? r15_val : r14_val;
        // zero immediate encodes the largest step (2**IMM_W words)
        imm_off  = {(imm == '0), imm, 2'b00};
        unique case (mode)
            EA_IMM:  ea = base_sel + ADDR_W'(imm_off);
            EA_IDX:  ea = base_sel + rm_val;
            default: ea = rm_val;
        endcase
    end
endmodule

// File: rtl/mau_win_align.sv
module mau_win_align
    import mau_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_LO = 32'h00F0_3000,
    parameter logic [ADDR_W-1:0] WIN_HI = 32'h00F0_3FFF
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic [1:0]        size,
    input  logic [1:0]        mode,
    input  logic              store,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] hi_data,
    output xfer_t             first,
    output xfer_t             second,
    output logic              two_part
);
    localparam int HALF_W = DATA_W / 2;
    localparam int LONG_B = LANES;

    logic              in_win;
    logic              clr_long;
    logic [ADDR_W-1:0] phr_base;

    always_comb begin
        in_win   = (ea >= WIN_LO) && (ea <= WIN_HI);
        clr_long = in_win || (!store && (mode == EA_BASE));
        phr_base = in_win ? {ea[ADDR_W-1:3], 3'b000} : ea;

        first         = '0;
        first.valid   = 1'b1;
        first.we      = store;
        first.loc_hit = in_win;
        first.size    = size;
        first.addr    = ea;
        second        = first;
        second.valid  = 1'b0;
        two_part      = 1'b0;

        unique case (size)
            SZ_BYTE: begin
                first.lanes = LANES'(1) << ea[1:0];
                first.wdata = DATA_W'(wr_data[7:0]) << {ea[1:0], 3'b000};
            end
            SZ_WORD: begin
                first.addr  = in_win ? {ea[ADDR_W-1:1], 1'b0} : ea;
                first.lanes = LANES'(2'b11);
                first.wdata = DATA_W'(wr_data[HALF_W-1:0]);
            end
            SZ_LONG: begin
                first.addr  = clr_long ? {ea[ADDR_W-1:2], 2'b00} : ea;
                first.lanes = '1;
                first.wdata = wr_data;
            end
            default: begin
                two_part       = 1'b1;
                first.size     = SZ_LONG;
                first.addr     = phr_base;
                first.lanes    = '1;
                first.wdata    = hi_data;
                first.hi_half  = 1'b1;
                second         = first;
                second.addr    = phr_base + ADDR_W'(LONG_B);
                second.wdata   = wr_data;
                second.hi_half = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mau_top.sv
module mau_top
    import mau_pkg::*;
#(
    parameter logic [31:0] WIN_LO = 32'h00F0_3000,
    parameter logic [31:0] WIN_HI = 32'h00F0_3FFF,
    parameter int          IMM_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic [1:0]       req_mode,
    input  logic [1:0]       req_size,
    input  logic             base_r15,
    input  logic [31:0]      rm_val,
    input  logic [31:0]      r14_val,
    input  logic [31:0]      r15_val,
    input  logic [IMM_W-1:0] imm5,
    input  logic [31:0]      wr_data,
    input  logic [31:0]      hi_data,
    output logic             busy,
    output logic             mem_valid,
    output logic             mem_we,
    output logic             mem_local,
    output logic             mem_hi,
    output logic [1:0]       mem_size,
    output logic [3:0]       mem_lanes,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata
);
    typedef struct packed {
        xfer_t cur;
        xfer_t pend;
    } seq_t;

    seq_t              st_d, st_q;
    logic [ADDR_W-1:0] ea;
    xfer_t             x_first, x_second;
    logic              split;
    logic              accept;

    mau_ea_gen #(.IMM_W(IMM_W)) u_ea (
        .mode    (req_mode),
        .sel_r15 (base_r15),
        .rm_val  (rm_val),
        .r14_val (r14_val),
        .r15_val (r15_val),
        .imm     (imm5),
        .ea      (ea)
    );

    mau_win_align #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_align (
        .ea       (ea),
        .size     (req_size),
        .mode     (req_mode),
        .store    (req_store),
        .wr_data  (wr_data),
        .hi_data  (hi_data),
        .first    (x_first),
        .second   (x_second),
        .two_part (split)
    );

    always_comb begin
        st_d           = st_q;
        st_d.cur.valid = 1'b0;
        accept         = req_valid && !st_q.pend.valid;
        if (st_q.pend.valid) begin
            st_d.cur        = st_q.pend;
            st_d.pend.valid = 1'b0;
        end else if (accept) begin
            st_d.cur        = x_first;
            st_d.pend       = x_second;
            st_d.pend.valid = split;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.pend.valid;
    assign mem_valid = st_q.cur.valid;
    assign mem_we    = st_q.cur.we;
    assign mem_local = st_q.cur.loc_hit;
    assign mem_hi    = st_q.cur.hi_half;
    assign mem_size  = st_q.cur.size;
    assign mem_lanes = st_q.cur.lanes;
    assign mem_addr  = st_q.cur.addr;
    assign mem_wdata = st_q.cur.wdata;
endmodule

// File: rtl/mau_top_chk.sv
module mau_top_chk #(
    parameter logic [31:0] WIN_LO = 32'h00F0_3000,
    parameter logic [31:0] WIN_HI = 32'h00F0_3FFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_valid,
    input logic        mem_we,
    input logic        mem_local,
    input logic        mem_hi,
    input logic [1:0]  mem_size,
    input logic [3:0]  mem_lanes,
    input logic [31:0] mem_addr
);
    // R8
    busy_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_valid && mem_hi));

    // R8
    busy_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R7
    phrase_second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (mem_valid && !mem_hi && mem_addr == $past(mem_addr) + 32'd4
                  && mem_we == $past(mem_we) && mem_size == 2'd2));

    // R2
    local_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_local) |-> (mem_addr >= WIN_LO && mem_addr <= WIN_HI));

    // R3
    local_long_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_local && mem_size == 2'd2) |-> (mem_addr[1:0] == 2'b00));

    // R6
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_size == 2'd0) |->
            ($countones(mem_lanes) == 1 && mem_lanes[mem_addr[1:0]]));
endmodule

bind mau_top mau_top_chk #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_local (mem_local),
    .mem_hi    (mem_hi),
    .mem_size  (mem_size),
    .mem_lanes (mem_lanes),
    .mem_addr  (mem_addr)
);

// File: tb/mau_top_test.sv
module mau_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic [1:0]  req_size = 2'd0;
    logic        base_r15 = 1'b0;
    logic [31:0] rm_val = '0, r14_val = '0, r15_val = '0;
    logic [4:0]  imm5 = '0;
    logic [31:0] wr_data = '0, hi_data = '0;
    logic        busy, mem_valid, mem_we, mem_local, mem_hi;
    logic [1:0]  mem_size;
    logic [3:0]  mem_lanes;
    logic [31:0] mem_addr, mem_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        we;
        logic        loc;
        logic        hi;
        logic [1:0]  size;
        logic [3:0]  lanes;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        bsy;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    mau_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_mode(req_mode), .req_size(req_size), .base_r15(base_r15),
        .rm_val(rm_val), .r14_val(r14_val), .r15_val(r15_val), .imm5(imm5),
        .wr_data(wr_data), .hi_data(hi_data), .busy(busy), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_local(mem_local), .mem_hi(mem_hi), .mem_size(mem_size),
        .mem_lanes(mem_lanes), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Scoreboard model built from the requirement text.
    task automatic push_expect(input logic st, input logic [1:0] md, input logic s15,
                               input logic [31:0] rm, r14, r15, input logic [4:0] im,
                               input logic [1:0] sz, input logic [31:0] wr, hi,
                               input string tag);
        logic [31:0] base, ea, off;
        bit          win;
        exp_t        e, e2;
        base = s15 ? r15 : r14;
        off  = (im == 5'd0) ? 32'd128 : {25'd0, im, 2'b00};
        if (md == 2'd1)      ea = base + off;
        else if (md == 2'd2) ea = base + rm;
        else                 ea = rm;
        win = (ea >= 32'h00F0_3000) && (ea <= 32'h00F0_3FFF);
        e.we = st; e.loc = win; e.hi = 1'b0; e.size = sz; e.bsy = 1'b0; e.tag = tag;
        case (sz)
            2'd0: begin
                e.addr = ea; e.lanes = 4'b0001 << ea[1:0];
                e.wdata = {24'd0, wr[7:0]} << (8 * ea[1:0]);
            end
            2'd1: begin
                e.addr = win ? (ea & ~32'd1) : ea; e.lanes = 4'b0011;
                e.wdata = {16'd0, wr[15:0]};
            end
            2'd2: begin
                e.addr = (win || (!st && md == 2'd0)) ? (ea & ~32'd3) : ea;
                e.lanes = 4'b1111; e.wdata = wr;
            end
            default: begin
                e.size = 2'd2; e.lanes = 4'b1111;
                e.addr = win ? (ea & ~32'd7) : ea;
                e.wdata = hi; e.hi = 1'b1; e.bsy = 1'b1;
                e2 = e;
                e2.addr = e.addr + 32'd4; e2.wdata = wr; e2.hi = 1'b0; e2.bsy = 1'b0;
            end
        endcase
        exp_q.push_back(e);
        if (sz == 2'd3) exp_q.push_back(e2);
    endtask

    // Driver: called at a negedge, returns at a later negedge.
    task automatic send(input logic st, input logic [1:0] md, input logic s15,
                        input logic [31:0] rm, r14, r15, input logic [4:0] im,
                        input logic [1:0] sz, input logic [31:0] wr, hi,
                        input bit junk, input string tag);
        push_expect(st, md, s15, rm, r14, r15, im, sz, wr, hi, tag);
        req_valid = 1'b1; req_store = st; req_mode = md; base_r15 = s15;
        rm_val = rm; r14_val = r14; r15_val = r15; imm5 = im; req_size = sz;
        wr_data = wr; hi_data = hi;
        @(negedge clk);
        if (sz == 2'd3) begin
            if (junk) begin
                // R8: offered while busy, must vanish
                req_store = 1'b1; req_mode = 2'd0; req_size = 2'd2;
                rm_val = 32'h0000_7770; wr_data = 32'hDEAD_BEEF;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && !done && mem_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected transfer addr", mem_addr, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.addr, e.tag, "addr", mem_addr, e.addr);
                check({mem_we, mem_local, mem_hi, mem_size, mem_lanes, busy} ==
                      {e.we, e.loc, e.hi, e.size, e.lanes, e.bsy}, e.tag,
                      "we/loc/hi/size/lanes/busy",
                      {22'd0, mem_we, mem_local, mem_hi, mem_size, mem_lanes, busy},
                      {22'd0, e.we, e.loc, e.hi, e.size, e.lanes, e.bsy});
                if (e.we) check(mem_wdata == e.wdata, e.tag, "wdata", mem_wdata, e.wdata);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(mem_valid == 1'b0 && busy == 1'b0, "R9", "reset valid/busy",
              {30'd0, mem_valid, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_valid == 1'b0, "R9", "idle after reset", {31'd0, mem_valid}, 32'd0);

        // R4 base long load outside window clears low bits
        send(0, 0, 0, 32'h0000_1236, 0, 0, 0, 2, 0, 0, 0, "R4");
        // R3 long store outside window unchanged
        send(1, 0, 0, 32'h0000_1236, 0, 0, 0, 2, 32'h1111_2222, 0, 0, "R3");
        // R3 long store inside window aligned
        send(1, 0, 0, 32'h00F0_3107, 0, 0, 0, 2, 32'h3333_4444, 0, 0, "R3");
        // R2 window edges, stores so only the window decides
        send(1, 0, 0, 32'h00F0_2FFF, 0, 0, 0, 2, 32'h5, 0, 0, "R2");
        send(1, 0, 0, 32'h00F0_3000, 0, 0, 0, 2, 32'h6, 0, 0, "R2");
        send(1, 0, 0, 32'h00F0_3FFF, 0, 0, 0, 2, 32'h7, 0, 0, "R2");
        send(1, 0, 0, 32'h00F0_4000, 0, 0, 0, 2, 32'h8, 0, 0, "R2");
        // R1 immediate zero means 32 words
        send(0, 1, 0, 0, 32'h00F0_3000, 32'h0, 5'd0, 2, 0, 0, 0, "R1");
        // R4 indexed long load outside keeps address (r15 + 5*4)
        send(0, 1, 1, 0, 32'h0, 32'h0000_2001, 5'd5, 2, 0, 0, 0, "R4");
        // R1 index-register mode via r15, inside window
        send(1, 2, 1, 32'h0000_0013, 32'h0, 32'h00F0_3200, 0, 2, 32'hCAFE_0001, 0, 0, "R1");
        // R4 index-register long load outside via r14
        send(0, 2, 0, 32'h0000_0003, 32'h0000_8000, 0, 0, 2, 0, 0, 0, "R4");
        // R5 word in / out of window
        send(1, 0, 0, 32'h00F0_3033, 0, 0, 0, 1, 32'hABCD_1234, 0, 0, "R5");
        send(1, 0, 0, 32'h0000_5001, 0, 0, 0, 1, 32'hABCD_5678, 0, 0, "R5");
        // R6 byte lanes
        send(1, 0, 0, 32'h00F0_3003, 0, 0, 0, 0, 32'h0000_005A, 0, 0, "R6");
        send(1, 0, 0, 32'h0000_0100, 0, 0, 0, 0, 32'h0000_00C3, 0, 0, "R6");
        send(1, 0, 0, 32'h0000_0102, 0, 0, 0, 0, 32'h0000_0077, 0, 0, "R6");
        // R7 phrase store inside window
        send(1, 0, 0, 32'h00F0_310D, 0, 0, 0, 3, 32'h0000_00B0, 32'h0000_00A0, 0, "R7");
        // R7 phrase load outside window
        send(0, 0, 0, 32'h0000_4002, 0, 0, 0, 3, 0, 0, 0, "R7");
        // R8 request during busy ignored
        send(1, 0, 0, 32'h00F0_3020, 0, 0, 0, 3, 32'h22, 32'h11, 1, "R8");
        // R9 back-to-back after the ignored slot
        send(1, 0, 0, 32'h0000_0040, 0, 0, 0, 2, 32'h40, 0, 0, "R9");
        send(1, 0, 0, 32'h0000_0044, 0, 0, 0, 2, 32'h44, 0, 0, "R9");
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending expected transfers",
              exp_q.size(), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule